// File: doc/BRIEF.md
# Flash Page ECC Accumulator

This block sits beside the byte-wide data path of a flash controller and builds a single-error-correcting Hamming code over the data stream. It sees each byte moved through the controller's data register. While accumulation is on, it folds those bytes into parity state. Each 256-byte chunk of a page gets its own 3-byte code, so the default two-chunk setup covers a 512-byte page with 6 code bytes.

A 2-bit mode input drives the block and is taken from the controller's mode register. To start a calculation, software selects clear, then off, then accumulate, and moves the page. It then selects readout and reads the data register once for each code byte. Error location and correction against the stored code are left to software.

Top module: `page_ecc_acc`

## Requirements
- R1: After `rst_ni` is released, every code byte read out is 8'hFF.
- R2: `mode_i` encodes 2'b00 as off, 2'b01 as accumulate, 2'b10 as readout and 2'b11 as clear.
- R3: Sixteen line parities are kept per chunk. For byte index bit k (0..7), LP(2k+1) is the XOR of all data bits of the chunk's bytes whose index has bit k set, and LP(2k) is the same XOR over bytes whose index has bit k clear.
- R4: Six column parities are kept per chunk as XORs over all bytes of the chunk. CP0 covers bits 0,2,4,6 and CP1 covers bits 1,3,5,7. CP2 covers bits 0,1,4,5 and CP3 covers bits 2,3,6,7. CP4 covers bits 0..3 and CP5 covers bits 4..7.
- R5: Each chunk's code holds inverted parities. Code byte 0 is ~LP7..~LP0 (LP0 in bit 0). Code byte 1 is ~LP15..~LP8. Code byte 2 is {~CP5..~CP0, 1, 1}. An all-ones chunk therefore gives FF FF FF.
- R6: The first 256 accepted bytes go to chunk 0 and the next 256 go to chunk 1, in strict order of arrival.
- R7: In readout mode, `code_o` shows the current code byte and each `xfer_i` pulse moves to the next one. The order runs chunk by chunk, and within a chunk it is byte 1, byte 0, byte 2.
- R8: On the first cycle that `mode_i` is readout after any other mode, the readout position returns to chunk 0, byte 1.
- R9: Transfers in off or readout mode leave the parity state unchanged.
- R10: Clear mode zeroes all parity state and the accepted-byte count, so the next accumulation starts again at chunk 0, index 0.
- R11: Once a full page of bytes has been accepted, further bytes in accumulate mode are ignored until the next clear.
- R12: After the last code byte of the last chunk, the next readout pulse wraps back to chunk 0, byte 1.
- R13: Cycles without `xfer_i` change no parity state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | ECC mode field (off / accumulate / readout / clear) |
| xfer_i | input | 1 | One data-register transfer this cycle |
| data_i | input | 8 | Byte on the data bus during a transfer |
| code_o | output | 8 | Current code byte, valid in readout mode |

## Verification
The assertions assume that `mode_i` is steady around each clock edge and that `xfer_i` marks exactly one byte per cycle. Under those conditions, state may change only on an enabled transfer or a clear, and the readout position stays inside the code table. The stimulus changes mode only on inactive clock phases and never overlaps a mode change with a transfer, except deliberately in readout. It mixes seeded random bytes, random idle gaps, off-mode and readout-mode transfers inside a page, an over-long page, an erased page, and a sparse single-bit page.

// File: rtl/page_ecc_pkg.sv
package page_ecc_pkg;
  typedef enum logic [1:0] {
    ECC_OFF  = 2'b00,
    ECC_ACC  = 2'b01,
    ECC_READ = 2'b10,
    ECC_CLR  = 2'b11
  } ecc_mode_e;

  localparam int unsigned ROW_W      = 8;   // byte index width inside a chunk
  localparam int unsigned CHUNK_LEN  = 1 << ROW_W;
  localparam int unsigned CODE_BYTES = 3;

  typedef struct packed {
    logic [ROW_W-1:0] row_odd; // parity of bytes whose index bit k is 1
    logic [7:0]       col;     // running XOR of all bytes
  } grp_par_t;
endpackage

// File: rtl/ecc_grp_acc.sv
module ecc_grp_acc
  import page_ecc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [ROW_W-1:0] idx_i,
  input  logic [7:0]       data_i,
  output grp_par_t         par_o
);
  grp_par_t par_q;
  logic     byte_par;

  assign byte_par = ^data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      par_q <= '0;
    end else if (clr_i) begin
      par_q <= '0;
    end else if (en_i) begin
      par_q.col     <= par_q.col ^ data_i;
      par_q.row_odd <= par_q.row_odd ^ (idx_i & {ROW_W{byte_par}});
    end
  end

  assign par_o = par_q;

  p_hold_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !en_i) |=> $stable(par_q));

  p_clear_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (par_q == '0));
endmodule

// File: rtl/ecc_code_pack.sv
module ecc_code_pack
  import page_ecc_pkg::*;
(
  input  grp_par_t        par_i,
  output logic [2:0][7:0] code_o
);
  logic             tot;
  logic [ROW_W-1:0] row_even;
  logic [15:0]      lp;
  logic [5:0]       cp;

  assign tot      = ^par_i.col;
  assign row_even = par_i.row_odd ^ {ROW_W{tot}};

  always_comb begin
    for (int k = 0; k < ROW_W; k++) begin
      lp[2*k]   = row_even[k];
      lp[2*k+1] = par_i.row_odd[k];
    end
  end

  assign cp[0] = par_i.col[0] ^ par_i.col[2] ^ par_i.col[4] ^ par_i.col[6];
  assign cp[1] = par_i.col[1] ^ par_i.col[3] ^ par_i.col[5] ^ par_i.col[7];
  assign cp[2] = par_i.col[0] ^ par_i.col[1] ^ par_i.col[4] ^ par_i.col[5];
  assign cp[3] = par_i.col[2] ^ par_i.col[3] ^ par_i.col[6] ^ par_i.col[7];
  assign cp[4] = ^par_i.col[3:0];
  assign cp[5] = ^par_i.col[7:4];

  // stored inverted: erased data reads back as all ones
  assign code_o[0] = ~lp[7:0];
  assign code_o[1] = ~lp[15:8];
  assign code_o[2] = ~{cp, 2'b00};
endmodule

// File: rtl/ecc_rd_seq.sv
module ecc_rd_seq #(
  parameter int unsigned NUM_GROUPS = 2,
  localparam int unsigned GW = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          enter_i,
  input  logic          adv_i,
  output logic [GW-1:0] grp_o,
  output logic [1:0]    slot_o
);
  logic [GW-1:0] grp_q, grp_d;
  logic [1:0]    slot_q, slot_d;

  // entering readout restarts at the first byte in the same cycle
  assign grp_o  = enter_i ? '0 : grp_q;
  assign slot_o = enter_i ? '0 : slot_q;

  always_comb begin
    grp_d  = grp_o;
    slot_d = slot_o;
    if (adv_i) begin
      if (slot_o == 2'd2) begin
        slot_d = '0;
        grp_d  = (grp_o == GW'(NUM_GROUPS - 1)) ? '0 : grp_o + 1'b1;
      end else begin
        slot_d = slot_o + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grp_q  <= '0;
      slot_q <= '0;
    end else begin
      grp_q  <= grp_d;
      slot_q <= slot_d;
    end
  end

  p_ptr_range_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_q <= 2'd2) && (grp_q <= GW'(NUM_GROUPS - 1)));

  p_entry_home_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enter_i && !adv_i) |=> (slot_q == 2'd0 && grp_q == '0));
endmodule

// File: rtl/page_ecc_acc.sv
module page_ecc_acc
  import page_ecc_pkg::*;
#(
  parameter int unsigned NUM_GROUPS = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       xfer_i,
  input  logic [7:0] data_i,
  output logic [7:0] code_o
);
  localparam int unsigned PAGE_LEN = NUM_GROUPS * CHUNK_LEN;
  localparam int unsigned CW = $clog2(PAGE_LEN + 1);
  localparam int unsigned GW = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1;

  ecc_mode_e mode, mode_q;
  logic      clr, acc_en, full, enter;
  logic [CW-1:0]         cnt_q;
  logic [GW-1:0]         grp_sel, rd_grp;
  logic [1:0]            rd_slot, byte_sel;
  logic [NUM_GROUPS-1:0] grp_en;
  logic [2:0][7:0]       codes [NUM_GROUPS];

  assign mode    = ecc_mode_e'(mode_i);
  assign clr     = (mode == ECC_CLR);
  assign full    = (cnt_q == CW'(PAGE_LEN));
  assign acc_en  = (mode == ECC_ACC) && xfer_i && !full;
  assign enter   = (mode == ECC_READ) && (mode_q != ECC_READ);
  assign grp_sel = GW'(cnt_q >> ROW_W);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= ECC_OFF;
      cnt_q  <= '0;
    end else begin
      mode_q <= mode;
      if (clr)         cnt_q <= '0;
      else if (acc_en) cnt_q <= cnt_q + 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    grp_par_t par;
    assign grp_en[g] = acc_en && (grp_sel == GW'(g));

    ecc_grp_acc u_acc (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr),
      .en_i   (grp_en[g]),
      .idx_i  (cnt_q[ROW_W-1:0]),
      .data_i (data_i),
      .par_o  (par)
    );

    ecc_code_pack u_pack (
      .par_i  (par),
      .code_o (codes[g])
    );
  end

  ecc_rd_seq #(.NUM_GROUPS(NUM_GROUPS)) u_rd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .enter_i (enter),
    .adv_i   ((mode == ECC_READ) && xfer_i),
    .grp_o   (rd_grp),
    .slot_o  (rd_slot)
  );

  // readout order inside a chunk: byte 1, byte 0, byte 2
  always_comb begin
    unique case (rd_slot)
      2'd0:    byte_sel = 2'd1;
      2'd1:    byte_sel = 2'd0;
      default: byte_sel = 2'd2;
    endcase
  end

  assign code_o = codes[rd_grp][byte_sel];

  p_one_chunk_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grp_en));

  p_page_sat_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full && !clr) |=> (full && $stable(cnt_q)));

  p_count_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |=> (cnt_q == '0));
endmodule

// File: tb/page_ecc_acc_tb.sv
`timescale 1ns/100ps
module page_ecc_acc_tb;
  localparam int NG   = 2;
  localparam int PAGE = NG * 256;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] mode_i = 2'b00;
  logic       xfer_i = 1'b0;
  logic [7:0] data_i = 8'h00;
  logic [7:0] code_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  logic [7:0] ref_mem [PAGE];
  int ref_cnt;

  always #2.5 clk = ~clk;

  page_ecc_acc #(.NUM_GROUPS(NG)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode_i),
    .xfer_i(xfer_i), .data_i(data_i), .code_o(code_o)
  );

  function automatic logic [23:0] ref_code(int g);
    logic [15:0] lp = '0;
    logic [5:0]  cp = '0;
    for (int i = 0; i < 256; i++) begin
      for (int b = 0; b < 8; b++) begin
        logic bit_v;
        bit_v = ref_mem[g*256 + i][b];
        for (int k = 0; k < 8; k++) begin
          if (i[k]) lp[2*k+1] ^= bit_v;
          else      lp[2*k]   ^= bit_v;
        end
        if (b % 2 == 0)       cp[0] ^= bit_v; else cp[1] ^= bit_v;
        if ((b / 2) % 2 == 0) cp[2] ^= bit_v; else cp[3] ^= bit_v;
        if (b < 4)            cp[4] ^= bit_v; else cp[5] ^= bit_v;
      end
    end
    return {~{cp, 2'b00}, ~lp[15:8], ~lp[7:0]};
  endfunction

  // readout position p -> expected byte (order 1,0,2 per chunk)
  function automatic logic [7:0] ref_byte(int p);
    logic [23:0] c;
    c = ref_code(p / 3);
    case (p % 3)
      0:       return c[15:8];
      1:       return c[7:0];
      default: return c[23:16];
    endcase
  endfunction

  task automatic chk(logic [7:0] got, logic [7:0] exp, string req);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic set_mode(logic [1:0] m);
    mode_i = m;
    @(negedge clk);
  endtask

  task automatic clr_ref();
    for (int i = 0; i < PAGE; i++) ref_mem[i] = 8'h00;
    ref_cnt = 0;
  endtask

  // R2: clear 11, off 00, accumulate 01
  task automatic start_calc();
    set_mode(2'b11);
    set_mode(2'b00);
    set_mode(2'b01);
    clr_ref();
  endtask

  task automatic push(logic [7:0] d);
    data_i = d;
    xfer_i = 1'b1;
    if (mode_i == 2'b01 && ref_cnt < PAGE) begin
      ref_mem[ref_cnt] = d;
      ref_cnt++;
    end
    @(negedge clk);
    xfer_i = 1'b0;
  endtask

  task automatic push_rand(int n, bit gaps);
    for (int i = 0; i < n; i++) begin
      push(8'($urandom));
      if (gaps && ($urandom % 4 == 0)) @(negedge clk); // R13 idle cycles
    end
  endtask

  task automatic rd_chk(logic [7:0] exp, string req);
    #1;
    chk(code_o, exp, req);
    xfer_i = 1'b1;
    @(negedge clk);
    xfer_i = 1'b0;
  endtask

  task automatic check_all(string req);
    set_mode(2'b10);
    for (int p = 0; p < 3*NG; p++) rd_chk(ref_byte(p), req);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20250));
    clr_ref();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1: fresh state reads as all ones
    check_all("R1 reset state");

    // R3 R4 R5 R6 R7 R13: random page with idle gaps
    start_calc();
    push_rand(PAGE, 1'b1);
    check_all("R3/R4/R5/R6/R7 random page");
    // R12: wrap to chunk 0 byte 1
    rd_chk(ref_byte(0), "R12 readout wrap");

    // R8: leave and re-enter readout mid-sequence
    set_mode(2'b00);
    set_mode(2'b10);
    rd_chk(ref_byte(0), "R8 re-entry restart");
    rd_chk(ref_byte(1), "R8 second after re-entry");

    // R9: off and readout transfers inside a page are not folded in
    start_calc();
    push_rand(100, 1'b0);
    set_mode(2'b00);
    push_rand(30, 1'b0);
    set_mode(2'b10);
    push_rand(4, 1'b0);
    set_mode(2'b01);
    push_rand(PAGE - 100, 1'b1);
    check_all("R9 off/readout bytes ignored");

    // R11: bytes past the page are ignored
    start_calc();
    push_rand(PAGE + 88, 1'b0);
    check_all("R11 page saturation");

    // R10: clear leaves all ones
    set_mode(2'b11);
    clr_ref();
    check_all("R10 clear mode");

    // R10: clear mid-page restarts the count at chunk 0 index 0
    start_calc();
    push_rand(200, 1'b0);
    start_calc();
    push_rand(PAGE, 1'b0);
    check_all("R10 restart after clear");

    // R5: erased page gives FF codes
    start_calc();
    for (int i = 0; i < PAGE; i++) push(8'hFF);
    for (int p = 0; p < 3*NG; p++) begin
      if (p == 0) set_mode(2'b10);
      rd_chk(8'hFF, "R5 erased page");
    end

    // R3 R4 R6: single set bit at chunk 1 index 0x55 bit 4
    start_calc();
    for (int i = 0; i < PAGE; i++) push((i == 256 + 8'h55) ? 8'h10 : 8'h00);
    check_all("R3/R4/R6 single bit");

    finish_run();
  end
endmodule